// File: doc/BRIEF.md
# Word-serial CRC32 stream checker

This block computes a 32-bit cyclic redundancy check over a stream of 32-bit words and checks it against a checksum word that follows the stream. It handles one data bit per clock. Words arrive on a valid/ready handshake. The producer marks the final covered word with a last flag. The next word accepted after that flagged word is taken as the appended checksum. The block compares that word with its own finalised CRC. It then reports the computed value and a match flag, with a one-cycle result-valid pulse.

Each bit step shifts the CRC register left by one. The current data bit enters at bit 0, least significant data bit of the word first. If the bit that left the top was 1, the register is XOR-ed with the generator 0x04C11DB7. This differs from the usual reflected, table-driven formulation, so the bench model follows the same step rule.

The control is a four-state machine:
- TAKE waits for a covered word. On a handshake it goes to SHIFT.
- SHIFT runs 32 bit steps with ready low. It then returns to TAKE, or goes to TAKE_SUM if the word carried the last flag.
- TAKE_SUM waits for the checksum word. On a handshake it goes to REPORT.
- REPORT lasts one cycle with result-valid high, then goes back to TAKE.

A start pulse forces the machine to TAKE from any state and restores the register to all ones.

Top module: `crc32_serial_chk`

## Requirements
- R1: After reset, `in_ready_o` is 1, `res_valid_o` is 0, `res_match_o` is 0 and `res_crc_o` is 0.
- R2: The CRC register starts from all ones. It uses the generator 0x04C11DB7 (x^32 + x^26 + x^23 + x^22 + x^16 + x^12 + x^11 + x^10 + x^8 + x^7 + x^5 + x^4 + x^2 + x + 1).
- R3: Each accepted word is consumed bit 0 first, one bit per clock. A step shifts the register left, puts the data bit into bit 0, and XORs in the generator when the outgoing bit 31 was 1.
- R4: After a covered word is accepted, `in_ready_o` is 0 for exactly 32 cycles.
- R5: The word accepted right after the word flagged with `in_last_i` is the checksum. The reported `res_crc_o` is the register XOR-ed with all ones.
- R6: `res_match_o` is 1 exactly when the checksum word equals the reported CRC.
- R7: `res_valid_o` is high for one cycle, in the cycle after the checksum handshake. `res_crc_o` and `res_match_o` hold their values until the next result.
- R8: `in_valid_i`, `in_data_i` and `in_last_i` have no effect while `in_ready_o` is 0. `in_last_i` is ignored on the checksum word.
- R9: A `start_i` pulse in any state abandons the stream in progress. It reloads all ones and raises `in_ready_o` in the following cycle.
- R10: After a result, the register is restored to all ones without any start pulse, so back-to-back streams are each checked from the initial value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Abandon the current stream and reload the register with all ones |
| in_valid_i | input | 1 | Word on `in_data_i` is offered |
| in_ready_o | output | 1 | Block can take a word this cycle |
| in_data_i | input | 32 | Covered word or checksum word |
| in_last_i | input | 1 | Marks the last covered word |
| res_valid_o | output | 1 | One-cycle pulse when a result is reported |
| res_crc_o | output | 32 | Finalised CRC of the last stream |
| res_match_o | output | 1 | Checksum word equalled the CRC |

## Verification
Streams of one to four words are run with all-zero, all-one, single-bit and multiplicative-hash contents. Each stream gets both a correct checksum and one with a single bit flipped, which separates the XOR and finalisation rules and the compare from each other. A sweep of one-word streams with the set bit at each of the 32 positions exposes any fault in bit order or in the feed-into-bit-0 rule. Junk valid, data and last values are driven during every busy window, and every stream runs back to back with no start. A start pulse given in the middle of a stream shows that the partial state is discarded.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

    localparam int unsigned CRC_W_DEFAULT = 32;
    localparam logic [31:0] CRC_GEN_DEFAULT = 32'h04C1_1DB7;

    typedef enum logic [1:0] {
        ST_TAKE     = 2'd0,
        ST_SHIFT    = 2'd1,
        ST_TAKE_SUM = 2'd2,
        ST_REPORT   = 2'd3
    } chk_state_t;

endpackage

// File: rtl/crc_bit_lane.sv
module crc_bit_lane #(
    parameter int unsigned           W   = 32,
    parameter logic [W-1:0]          GEN = 32'h04C1_1DB7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         step_i,
    output logic [W-1:0] crc_o
);

    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic [W-1:0] crc_q;
    logic [W-1:0] sh_q;
    logic [W-1:0] crc_shifted;

    always_comb begin
        crc_shifted = {crc_q[W-2:0], sh_q[0]};
        if (crc_q[W-1]) begin
            crc_shifted = crc_shifted ^ GEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= ONES;
        end else if (init_i) begin
            crc_q <= ONES;
        end else if (step_i) begin
            crc_q <= crc_shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= word_i;
        end else if (step_i) begin
            sh_q <= {1'b0, sh_q[W-1:1]};
        end
    end

    assign crc_o = crc_q;

    AST_INIT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (crc_o == ONES)); // R2

    AST_FEED_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !init_i) |=> (crc_o[0] == ($past(sh_q[0]) ^ (GEN[0] & $past(crc_o[W-1]))))); // R3

endmodule

// File: rtl/crc_seq_fsm.sv
module crc_seq_fsm
    import crc_serial_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic in_valid_i,
    input  logic in_last_i,
    output logic in_ready_o,
    output logic load_o,
    output logic step_o,
    output logic init_o,
    output logic sum_take_o,
    output logic res_valid_o
);

    localparam int unsigned          CNT_W    = $clog2(W);
    localparam logic [CNT_W-1:0]     LAST_BIT = CNT_W'(W - 1);

    chk_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_q;
    logic             accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TAKE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_TAKE;
        end else begin
            unique case (state_q)
                ST_TAKE:     if (in_valid_i) state_d = ST_SHIFT;
                ST_SHIFT:    if (cnt_q == LAST_BIT) state_d = last_q ? ST_TAKE_SUM : ST_TAKE;
                ST_TAKE_SUM: if (in_valid_i) state_d = ST_REPORT;
                ST_REPORT:   state_d = ST_TAKE;
            endcase
        end
    end

    always_comb begin
        in_ready_o  = (state_q == ST_TAKE) || (state_q == ST_TAKE_SUM);
        accept      = in_valid_i && in_ready_o && !start_i;
        load_o      = accept && (state_q == ST_TAKE);
        sum_take_o  = accept && (state_q == ST_TAKE_SUM);
        step_o      = (state_q == ST_SHIFT) && !start_i;
        init_o      = start_i || sum_take_o;
        res_valid_o = (state_q == ST_REPORT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else if (load_o) begin
            cnt_q  <= '0;
            last_q <= in_last_i;
        end else if (step_o) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !in_ready_o); // R4

    AST_RESULT_FROM_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(sum_take_o)); // R5

    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o); // R7

endmodule

// File: rtl/crc32_serial_chk.sv
module crc32_serial_chk
    import crc_serial_pkg::*;
#(
    parameter int unsigned  W   = CRC_W_DEFAULT,
    parameter logic [W-1:0] GEN = CRC_GEN_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         in_valid_i,
    output logic         in_ready_o,
    input  logic [W-1:0] in_data_i,
    input  logic         in_last_i,
    output logic         res_valid_o,
    output logic [W-1:0] res_crc_o,
    output logic         res_match_o
);

    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic         load_w, step_w, init_w, sum_take_w;
    logic [W-1:0] crc_w;
    logic [W-1:0] final_w;

    crc_seq_fsm #(.W(W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .in_valid_i  (in_valid_i),
        .in_last_i   (in_last_i),
        .in_ready_o  (in_ready_o),
        .load_o      (load_w),
        .step_o      (step_w),
        .init_o      (init_w),
        .sum_take_o  (sum_take_w),
        .res_valid_o (res_valid_o)
    );

    crc_bit_lane #(.W(W), .GEN(GEN)) u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (init_w),
        .load_i (load_w),
        .word_i (in_data_i),
        .step_i (step_w),
        .crc_o  (crc_w)
    );

    assign final_w = crc_w ^ ONES;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_crc_o   <= '0;
            res_match_o <= 1'b0;
        end else if (sum_take_w) begin
            res_crc_o   <= final_w;
            res_match_o <= (final_w == in_data_i);
        end
    end

    AST_START_READY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> in_ready_o); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> ($stable(res_crc_o) && $stable(res_match_o))); // R7

endmodule

// File: tb/crc32_serial_chk_tb_top.sv
module crc32_serial_chk_tb_top;

    localparam logic [31:0] GEN = 32'h04C1_1DB7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic        in_ready_o;
    logic [31:0] in_data_i = '0;
    logic        in_last_i = 1'b0;
    logic        res_valid_o;
    logic [31:0] res_crc_o;
    logic        res_match_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] wbuf [8];

    always #2 clk = ~clk;

    crc32_serial_chk dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .in_valid_i  (in_valid_i),
        .in_ready_o  (in_ready_o),
        .in_data_i   (in_data_i),
        .in_last_i   (in_last_i),
        .res_valid_o (res_valid_o),
        .res_crc_o   (res_crc_o),
        .res_match_o (res_match_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int w = 0; w < n; w++) begin
            for (int b = 0; b < 32; b++) begin
                logic top = c[31];
                c = {c[30:0], wbuf[w][b]};
                if (top) c = c ^ GEN;
            end
        end
        return ~c;
    endfunction

    task automatic wait_ready();
        @(negedge clk);
        while (!in_ready_o) @(negedge clk);
    endtask

    // covered word; junk driven on inputs during the busy window (R8)
    task automatic send_word(input logic [31:0] w, input bit last);
        int busy = 0;
        wait_ready();
        in_valid_i = 1'b1; in_data_i = w; in_last_i = last;
        @(negedge clk);
        in_data_i = ~w ^ 32'h5A5A_0F0F; in_last_i = ~last;
        while (!in_ready_o) begin
            busy++;
            @(negedge clk);
        end
        in_valid_i = 1'b0; in_last_i = 1'b0;
        check(busy == 32, "R4", "busy cycles", busy, 32);
    endtask

    task automatic run_stream(input int n, input logic [31:0] sum, input bit exp_match,
                              input string tag);
        logic [31:0] expc = ref_crc(n);
        logic [31:0] held;
        for (int i = 0; i < n; i++) send_word(wbuf[i], i == n - 1);
        wait_ready();
        in_valid_i = 1'b1; in_data_i = sum; in_last_i = 1'b1; // R8 last ignored on checksum
        @(negedge clk);
        in_valid_i = 1'b0; in_last_i = 1'b0;
        check(res_valid_o == 1'b1, "R7", {tag, " pulse"}, 32'(res_valid_o), 1);
        check(res_crc_o == expc, "R3", {tag, " crc"}, res_crc_o, expc);
        check(res_match_o == exp_match, "R6", {tag, " match"}, 32'(res_match_o), 32'(exp_match));
        held = res_crc_o;
        @(negedge clk);
        check(res_valid_o == 1'b0 && res_crc_o == held, "R7", {tag, " one-cycle/hold"},
              res_crc_o, held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(in_ready_o == 1'b1, "R1", "ready", 32'(in_ready_o), 1);
        check(res_valid_o == 1'b0, "R1", "res_valid", 32'(res_valid_o), 0);
        check(res_match_o == 1'b0, "R1", "match", 32'(res_match_o), 0);
        check(res_crc_o == 32'h0, "R1", "crc", res_crc_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R5 R10: single zero word against known value, no start used
        wbuf[0] = 32'h0;
        run_stream(1, ref_crc(1), 1'b1, "R2 zero word");

        // length x pattern sweep, back to back (R10)
        for (int n = 1; n <= 4; n++) begin
            for (int p = 0; p < 4; p++) begin
                for (int i = 0; i < n; i++) begin
                    case (p)
                        0: wbuf[i] = 32'h0;
                        1: wbuf[i] = 32'hFFFF_FFFF;
                        2: wbuf[i] = 32'h1 << ((i * 5 + 3) % 32);
                        default: wbuf[i] = 32'h9E37_79B9 * (i + 1 + n);
                    endcase
                end
                run_stream(n, ref_crc(n), 1'b1, "R10 sweep ok");
                run_stream(n, ref_crc(n) ^ (32'h1 << ((n * 7 + p) % 32)), 1'b0, "R6 sweep bad");
            end
        end

        // R3 bit position sweep on one word
        for (int k = 0; k < 32; k++) begin
            wbuf[0] = 32'h1 << k;
            run_stream(1, ref_crc(1), 1'b1, "R3 bit sweep");
        end

        // R9 start during a partial stream
        send_word(32'hDEAD_BEEF, 1'b0);
        wait_ready();
        in_valid_i = 1'b1; in_data_i = 32'h1234_5678; in_last_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0; in_last_i = 1'b0;
        repeat (5) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(in_ready_o == 1'b1, "R9", "ready after start", 32'(in_ready_o), 1);
        wbuf[0] = 32'hCAFE_F00D; wbuf[1] = 32'h0BAD_C0DE;
        run_stream(2, ref_crc(2), 1'b1, "R9 after start");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule